// File: doc/BRIEF.md
# Hardwired Processor Control Sequencer

This block is the control unit of a small single-bus processor. A step counter selects the current time slot. Each slot is decoded to one of seven one-hot lines. The opcode that the datapath's instruction register presents is decoded to one-hot instruction lines. A sum-of-products encoder then combines the slot lines, the instruction lines, the negative flag and the memory-complete input, and from them it drives the datapath strobes for that cycle. The strobes are the register in and out enables, the adder command, the adder input select, the memory read request, wait-for-memory and end-of-instruction.

Every instruction begins with the same three fetch slots. Three instructions are decoded: an add whose source operand comes from memory through register R3 into R1, an unconditional relative branch, and a branch taken when the result is negative. Any other opcode ends right after fetch. End-of-instruction returns the counter to the first slot. While wait-for-memory is raised and memory has not yet completed, the counter holds and the strobes of that slot repeat.

Top module: `hw_ctrl_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, step_o is 7'b0000001 (slot 1), and the outputs show the slot 1 strobes.
- R2: step_o always has exactly one bit set. Bit k-1 marks slot k. On each rising clock edge where the counter is neither stalled nor ended, it moves to the next slot.
- R3: Slots 1 to 3 are the same for every opcode. Slot 1 raises pc_out, mar_in, read, sel_four, add and z_in. Slot 2 raises z_out, pc_in, y_in and wmfc. Slot 3 raises mdr_out and ir_in.
- R4: For the add opcode (4'h1) the strobes are as follows. Slot 4 raises r3_out, mar_in and read. Slot 5 raises r1_out, y_in and wmfc. Slot 6 raises mdr_out, add and z_in, with sel_four low so that Y is selected. Slot 7 raises z_out, r1_in and end.
- R5: For the branch opcode (4'h2), slot 4 raises off_out, add and z_in. Slot 5 raises z_out, pc_in and end.
- R6: For branch-if-negative (4'h3), slot 4 raises off_out, add and z_in. With n_i=1 it goes on to slot 5, which raises z_out, pc_in and end. With n_i=0, end is raised in slot 4 and pc_in is not raised.
- R7: z_in is high in slot 1, in slot 6 of add, and in slot 4 of either branch, and in no other slot.
- R8: After a cycle with end high, the next rising edge puts the counter back in slot 1.
- R9: In a cycle where wmfc is high and mfc_i is low, the clock edge leaves step_o and all strobes unchanged. mfc_i has no effect in slots that do not raise wmfc.
- R10: Any opcode other than 4'h1, 4'h2 and 4'h3 raises only end in slot 4.
- R11: At most one of pc_out, mdr_out, z_out, r1_out, r3_out and off_out is high in any cycle.
- R12: The instruction decoder raises at most one instruction line. The add line corresponds to opcode 4'h1, the branch line to 4'h2 and the branch-if-negative line to 4'h3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode held in the instruction register |
| n_i | input | 1 | Negative condition flag |
| mfc_i | input | 1 | Memory function complete |
| step_o | output | 7 | One-hot current slot |
| pc_out_o | output | 1 | PC drives bus |
| pc_in_o | output | 1 | PC loads from bus |
| mar_in_o | output | 1 | MAR loads from bus |
| mdr_out_o | output | 1 | MDR drives bus |
| ir_in_o | output | 1 | IR loads from bus |
| y_in_o | output | 1 | Y loads from bus |
| z_in_o | output | 1 | Z loads adder result |
| z_out_o | output | 1 | Z drives bus |
| r1_in_o | output | 1 | R1 loads from bus |
| r1_out_o | output | 1 | R1 drives bus |
| r3_out_o | output | 1 | R3 drives bus |
| off_out_o | output | 1 | IR offset field drives bus |
| sel_four_o | output | 1 | Adder A input: 1 selects constant 4, 0 selects Y |
| add_o | output | 1 | Adder performs addition |
| read_o | output | 1 | Memory read request |
| wmfc_o | output | 1 | Wait for memory completion |
| end_o | output | 1 | End of instruction |

## Verification
The strobes are combinational in the registered slot and the live inputs. A change on opcode_i, n_i or mfc_i therefore shows on the strobes in the same cycle, and a slot change shows only after the next rising edge. The bench drives each table row at a falling edge and samples one nanosecond later, so the row it checks describes the slot reached at the previous rising edge. Stall rows hold mfc_i low in a wait slot and expect the same slot on the following row. Rows after an end expect slot 1 again, and a reset in the middle of an instruction is checked before any edge arrives.

// File: rtl/hw_ctrl_pkg.sv
package hw_ctrl_pkg;
  localparam int OP_W  = 4;
  localparam int NINS  = 3;
  localparam int I_ADD = 0;
  localparam int I_BR  = 1;
  localparam int I_BRN = 2;

  localparam logic [OP_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OP_W-1:0] OPC_BR  = 4'h2;
  localparam logic [OP_W-1:0] OPC_BRN = 4'h3;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mdr_out;
    logic ir_in;
    logic y_in;
    logic z_in;
    logic z_out;
    logic r1_in;
    logic r1_out;
    logic r3_out;
    logic off_out;
    logic sel_four;
    logic alu_add;
    logic read;
    logic wmfc;
    logic end_op;
  } ctrl_t;

  function automatic logic [OP_W-1:0] opc_of(input int idx);
    case (idx)
      I_ADD:   return OPC_ADD;
      I_BR:    return OPC_BR;
      default: return OPC_BRN;
    endcase
  endfunction
endpackage

// File: rtl/hw_step_counter.sv
module hw_step_counter #(
  parameter int NSTEP = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             end_i,
  output logic [NSTEP-1:0] step_o
);
  localparam int CW = $clog2(NSTEP);
  localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (end_i)             cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == LAST)        cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NSTEP; k++) begin : g_slot
    assign step_o[k] = (cnt_q == CW'(k));
  end

  p_step_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);

  p_end_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> step_o[0]);
endmodule

// File: rtl/hw_instr_decoder.sv
module hw_instr_decoder
  import hw_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  output logic [NINS-1:0] ins_o
);
  for (genvar i = 0; i < NINS; i++) begin : g_line
    assign ins_o[i] = (op_i == opc_of(i));
  end

  p_ins_onehot0_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ins_o));

  p_add_line_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'h1) |-> ins_o[I_ADD]);
endmodule

// File: rtl/hw_ctrl_encoder.sv
module hw_ctrl_encoder
  import hw_ctrl_pkg::*;
#(
  parameter int NSTEP = 7
) (
  input  logic [NSTEP-1:0] t_i,
  input  logic [NINS-1:0]  ins_i,
  input  logic             n_i,
  output ctrl_t            ctrl_o
);
  logic t1, t2, t3, t4, t5, t6, t7;
  logic is_add, is_br, is_brn, is_brx, is_undef;

  assign {t7, t6, t5, t4, t3, t2, t1} = t_i[6:0];
  assign is_add   = ins_i[I_ADD];
  assign is_br    = ins_i[I_BR];
  assign is_brn   = ins_i[I_BRN];
  assign is_brx   = is_br | is_brn;
  assign is_undef = ~|ins_i;

  // sum of products over slot, instruction and flag
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.pc_out   = t1;
    ctrl_o.mar_in   = t1 | (t4 & is_add);
    ctrl_o.read     = t1 | (t4 & is_add);
    ctrl_o.sel_four = t1;
    ctrl_o.alu_add  = t1 | (t6 & is_add) | (t4 & is_brx);
    ctrl_o.z_in     = t1 | (t6 & is_add) | (t4 & is_brx);
    ctrl_o.z_out    = t2 | (t7 & is_add) | (t5 & is_brx);
    ctrl_o.pc_in    = t2 | (t5 & is_brx);
    ctrl_o.y_in     = t2 | (t5 & is_add);
    ctrl_o.wmfc     = t2 | (t5 & is_add);
    ctrl_o.mdr_out  = t3 | (t6 & is_add);
    ctrl_o.ir_in    = t3;
    ctrl_o.r3_out   = t4 & is_add;
    ctrl_o.r1_out   = t5 & is_add;
    ctrl_o.r1_in    = t7 & is_add;
    ctrl_o.off_out  = t4 & is_brx;
    ctrl_o.end_op   = (t7 & is_add) | (t5 & is_brx) | (t4 & is_brn & ~n_i)
                    | (t4 & is_undef);
  end
endmodule

// File: rtl/hw_ctrl_seq.sv
module hw_ctrl_seq
  import hw_ctrl_pkg::*;
#(
  parameter int STEPS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       opcode_i,
  input  logic             n_i,
  input  logic             mfc_i,
  output logic [STEPS-1:0] step_o,
  output logic             pc_out_o,
  output logic             pc_in_o,
  output logic             mar_in_o,
  output logic             mdr_out_o,
  output logic             ir_in_o,
  output logic             y_in_o,
  output logic             z_in_o,
  output logic             z_out_o,
  output logic             r1_in_o,
  output logic             r1_out_o,
  output logic             r3_out_o,
  output logic             off_out_o,
  output logic             sel_four_o,
  output logic             add_o,
  output logic             read_o,
  output logic             wmfc_o,
  output logic             end_o
);
  logic [STEPS-1:0] step;
  logic [NINS-1:0]  ins;
  ctrl_t            ctrl;
  logic             run;

  // RUN drops while waiting on memory
  assign run = ~(ctrl.wmfc & ~mfc_i);

  hw_step_counter #(.NSTEP(STEPS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .end_i (ctrl.end_op),
    .step_o(step)
  );

  hw_instr_decoder u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (opcode_i),
    .ins_o (ins)
  );

  hw_ctrl_encoder #(.NSTEP(STEPS)) u_enc (
    .t_i   (step),
    .ins_i (ins),
    .n_i   (n_i),
    .ctrl_o(ctrl)
  );

  assign step_o     = step;
  assign pc_out_o   = ctrl.pc_out;
  assign pc_in_o    = ctrl.pc_in;
  assign mar_in_o   = ctrl.mar_in;
  assign mdr_out_o  = ctrl.mdr_out;
  assign ir_in_o    = ctrl.ir_in;
  assign y_in_o     = ctrl.y_in;
  assign z_in_o     = ctrl.z_in;
  assign z_out_o    = ctrl.z_out;
  assign r1_in_o    = ctrl.r1_in;
  assign r1_out_o   = ctrl.r1_out;
  assign r3_out_o   = ctrl.r3_out;
  assign off_out_o  = ctrl.off_out;
  assign sel_four_o = ctrl.sel_four;
  assign add_o      = ctrl.alu_add;
  assign read_o     = ctrl.read;
  assign wmfc_o     = ctrl.wmfc;
  assign end_o      = ctrl.end_op;

  p_one_driver_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pc_out_o, mdr_out_o, z_out_o, r1_out_o, r3_out_o, off_out_o}) <= 1);

  p_zin_slots_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_in_o |-> (step_o[0] | (step_o[5] & (opcode_i == 4'h1))
               | (step_o[3] & ((opcode_i == 4'h2) | (opcode_i == 4'h3)))));

  p_brn_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[3] && opcode_i == 4'h3 && !n_i) |-> (end_o && !pc_in_o));

  p_undef_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[3] && opcode_i != 4'h1 && opcode_i != 4'h2 && opcode_i != 4'h3)
      |-> (end_o && !z_in_o && !read_o));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wmfc_o && !mfc_i) |=> $stable(step_o));

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!wmfc_o || mfc_i) && !end_o && !step_o[STEPS-1])
      |=> (step_o == ($past(step_o) << 1)));
endmodule

// File: tb/sim_hw_ctrl_seq.sv
module sim_hw_ctrl_seq;
  localparam int CLK_P = 10;
  localparam int NV    = 29;

  // strobe bit positions (MSB first): pc_out pc_in mar_in mdr_out ir_in y_in
  // z_in z_out r1_in r1_out r3_out off_out sel_four add read wmfc end
  localparam logic [16:0] PCO = 17'h10000, PCI = 17'h08000, MARI = 17'h04000,
                          MDRO = 17'h02000, IRI = 17'h01000, YI = 17'h00800,
                          ZI = 17'h00400, ZO = 17'h00200, R1I = 17'h00100,
                          R1O = 17'h00080, R3O = 17'h00040, OFO = 17'h00020,
                          S4 = 17'h00010, AD = 17'h00008, RD = 17'h00004,
                          WM = 17'h00002, EN = 17'h00001;
  localparam logic [16:0] F1 = PCO | MARI | RD | S4 | AD | ZI;
  localparam logic [16:0] F2 = ZO | PCI | YI | WM;
  localparam logic [16:0] F3 = MDRO | IRI;
  localparam logic [16:0] A4 = R3O | MARI | RD;
  localparam logic [16:0] A5 = R1O | YI | WM;
  localparam logic [16:0] A6 = MDRO | AD | ZI;
  localparam logic [16:0] A7 = ZO | R1I | EN;
  localparam logic [16:0] B4 = OFO | AD | ZI;
  localparam logic [16:0] B5 = ZO | PCI | EN;

  // row: opcode[25:22] n[21] mfc[20] slot[19:17] strobes[16:0]
  localparam logic [25:0] VECS [NV] = '{
    {4'h1,1'b0,1'b0,3'd1,F1}, {4'h1,1'b0,1'b0,3'd2,F2}, {4'h1,1'b1,1'b1,3'd2,F2},
    {4'h1,1'b1,1'b0,3'd3,F3}, {4'h1,1'b1,1'b0,3'd4,A4}, {4'h1,1'b1,1'b0,3'd5,A5},
    {4'h1,1'b0,1'b0,3'd5,A5}, {4'h1,1'b0,1'b1,3'd5,A5}, {4'h1,1'b0,1'b0,3'd6,A6},
    {4'h1,1'b0,1'b0,3'd7,A7},
    {4'h2,1'b0,1'b0,3'd1,F1}, {4'h2,1'b0,1'b1,3'd2,F2}, {4'h2,1'b0,1'b0,3'd3,F3},
    {4'h2,1'b0,1'b0,3'd4,B4}, {4'h2,1'b1,1'b0,3'd5,B5},
    {4'h3,1'b1,1'b0,3'd1,F1}, {4'h3,1'b1,1'b1,3'd2,F2}, {4'h3,1'b1,1'b0,3'd3,F3},
    {4'h3,1'b1,1'b0,3'd4,B4}, {4'h3,1'b1,1'b0,3'd5,B5},
    {4'h3,1'b0,1'b0,3'd1,F1}, {4'h3,1'b0,1'b1,3'd2,F2}, {4'h3,1'b0,1'b0,3'd3,F3},
    {4'h3,1'b0,1'b0,3'd4,B4 | EN},
    {4'hF,1'b0,1'b0,3'd1,F1}, {4'hF,1'b0,1'b1,3'd2,F2}, {4'hF,1'b1,1'b0,3'd3,F3},
    {4'hF,1'b1,1'b0,3'd4,EN},
    {4'h1,1'b0,1'b0,3'd1,F1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic n_flag = 1'b0;
  logic mfc = 1'b0;
  logic [6:0] step;
  logic pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, z_in, z_out;
  logic r1_in, r1_out, r3_out, off_out, sel_four, add, rd, wmfc, end_s;
  logic [16:0] obs;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hw_ctrl_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .n_i(n_flag), .mfc_i(mfc),
    .step_o(step), .pc_out_o(pc_out), .pc_in_o(pc_in), .mar_in_o(mar_in),
    .mdr_out_o(mdr_out), .ir_in_o(ir_in), .y_in_o(y_in), .z_in_o(z_in),
    .z_out_o(z_out), .r1_in_o(r1_in), .r1_out_o(r1_out), .r3_out_o(r3_out),
    .off_out_o(off_out), .sel_four_o(sel_four), .add_o(add), .read_o(rd),
    .wmfc_o(wmfc), .end_o(end_s)
  );

  assign obs = {pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, z_in, z_out,
                r1_in, r1_out, r3_out, off_out, sel_four, add, rd, wmfc, end_s};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [25:0] v);
    if (v[1] && !v[20])    return "R9";
    if (v[19:17] == 3'd1)  return "R8";
    if (v[19:17] <= 3'd3)  return "R3";
    case (v[25:22])
      4'h1:    return "R4/R12";
      4'h2:    return "R5";
      4'h3:    return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    @(negedge clk);
    chk(step == 7'b0000001, "R1", "slot in reset", 32'(step), 32'h1);
    chk(obs == F1, "R1", "strobes in reset", 32'(obs), 32'(F1));
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      opcode = VECS[i][25:22];
      n_flag = VECS[i][21];
      mfc    = VECS[i][20];
      #1;
      chk(step == (7'b1 << (VECS[i][19:17] - 3'd1)), "R2", "slot",
          32'(step), 32'(7'b1 << (VECS[i][19:17] - 3'd1)));
      chk(obs == VECS[i][16:0], tag_of(VECS[i]), "strobes",
          32'(obs), 32'(VECS[i][16:0]));
      chk(z_in == VECS[i][10], "R7", "z_in", 32'(z_in), 32'(VECS[i][10]));
      chk($countones({pc_out, mdr_out, z_out, r1_out, r3_out, off_out}) <= 1,
          "R11", "bus drivers", 32'(obs), 32'(VECS[i][16:0]));
      @(negedge clk);
    end
    // now in slot 2 of an add; run to slot 4 then reset mid-instruction
    opcode = 4'h1; mfc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(step == 7'b0001000, "R2", "slot before reset", 32'(step), 32'h8);
    chk(obs == A4, "R4", "strobes before reset", 32'(obs), 32'(A4));
    rst_ni = 1'b0;
    #1;
    chk(step == 7'b0000001, "R1", "slot after async reset", 32'(step), 32'h1);
    chk(obs == F1, "R1", "strobes after async reset", 32'(obs), 32'(F1));
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(step == 7'b0000001, "R1", "slot after release", 32'(step), 32'h1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule